// File: doc/BRIEF.md
# Camera Link frame readout timer

This block produces the vertical and horizontal framing for a camera output stream. An exposure is opened by a start pulse and closed by a stop pulse. The block holds the exposure-active flag high for at least a programmable number of cycles. After the exposure ends and a programmable delay passes, it opens a frame. Each frame raises frame valid first and runs a number of blank offset lines. It then runs the active lines. Line valid covers the first part of each line period, and data valid covers the pixel slots. A per-clock count gives how many pixels travel in the current slot, based on the tap geometry: 2, 4, 8 or 10 pixels per clock.

The overlap mode can be set to readout. In that mode, an exposure that begins while frame valid is high freezes the line readout for exactly 16 line periods. Frame valid therefore stays high 16 lines longer, and every line and pixel is still delivered afterwards. Horizontal binning halves the pixels per line but keeps the line period, so the frame time does not change. Data valid and exposure-active are mirrored onto two spare-bit outputs. In the two 80-bit configurations those bits carry pixel data, so both mirrors are held low. The line geometry and pixel format are captured once, when each frame opens.

Top module: `cam_frame_timer`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs go low on that edge: frame valid, line valid, data valid, exposure-active, both spare bits, and the tap count.
- R2: With no frame in progress, `fval` rises exactly `cfg_exp_dly`+1 clock cycles after `exp_act` falls.
- R3: With no pause, a frame holds `fval` high for (`cfg_voff`+`cfg_lines`)×`cfg_line_len` cycles. The first `lval` cycle comes `cfg_voff`×`cfg_line_len` cycles after `fval` rises.
- R4: Each active line holds `lval` high for `cfg_line_len`−`cfg_hblank` cycles, so a frame has `cfg_lines` of them. Offset lines have no `lval`.
- R5: `cfg_geom` selects the taps: 0 gives 2, 1 gives 4, 2 gives 8 and 3 gives 10. On each line, `dval` is high for ceil(pixels/taps) cycles starting at the first `lval` cycle. `tap_cnt` gives the pixels in each slot (taps, or fewer in the last slot), so the counts add up to the pixels per line.
- R6: With `cfg_hbin` set, each line carries floor(`cfg_pixels`/2) pixels. The frame length is unchanged.
- R7: With `cfg_ovl_readout` set, an accepted exposure start while `fval` is high freezes the readout for 16×`cfg_line_len` cycles. During the freeze `lval` and `dval` stay low. `fval` lasts exactly that much longer, and the totals of `lval` cycles and pixels are unchanged.
- R8: An exposure start while `fval` is low causes no pause: the next frame has the normal length.
- R9: With `cfg_ovl_readout` clear, an exposure during a frame does not lengthen that frame.
- R10: Outside the 80-bit modes, `spare_dval` equals `dval` and `spare_exp` equals `exp_act`.
- R11: In the 80-bit modes (`cfg_geom`=3 with `cfg_px10`=0, or `cfg_geom`=2 with `cfg_px10`=1), both spare bits stay low during the frame.
- R12: `exp_act` stays high for at least `cfg_exp_min` cycles, even if the stop pulse comes earlier.
- R13: The line length, blanking, offset lines, line count, pixel count, binning and pixel format are captured when `fval` rises. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_line_len | input | LW | Line period in clocks |
| cfg_hblank | input | LW | Blank clocks at the end of each line |
| cfg_voff | input | VW | Offset lines before active lines |
| cfg_lines | input | VW | Active lines per frame |
| cfg_pixels | input | PW | Pixels per line before binning |
| cfg_hbin | input | 1 | Horizontal binning by two |
| cfg_geom | input | 2 | Tap geometry select |
| cfg_px10 | input | 1 | 1 = 10-bit pixels, 0 = 8-bit |
| cfg_ovl_readout | input | 1 | Pause readout on exposure start in a frame |
| cfg_exp_min | input | EW | Minimum exposure-active width |
| cfg_exp_dly | input | EW | Delay from exposure end to frame start |
| exp_start | input | 1 | Exposure start pulse |
| exp_stop | input | 1 | Exposure stop pulse |
| fval | output | 1 | Frame valid |
| lval | output | 1 | Line valid |
| dval | output | 1 | Data valid |
| exp_act | output | 1 | Exposure active |
| tap_cnt | output | 4 | Pixels carried in this clock |
| spare_dval | output | 1 | Data valid on the spare bit |
| spare_exp | output | 1 | Exposure active on the spare bit |

## Verification
`exp_act` rises one edge after the `exp_start` pulse. It falls at the first edge at which the stop has been seen and the width has reached `cfg_exp_min`. `fval` then rises `cfg_exp_dly`+1 edges later. Line valid, data valid and the tap count are combinational views of the registered counters, so they settle in the same cycle as those counters. A pause begins on the edge after the accepted exposure start. The bench samples every output on the falling clock edge and accumulates per-frame totals: frame cycles, offset before the first line, lval cycles, dval cycles, pixel sum and spare-bit disagreements. It compares those totals with values computed from the configuration. A timing error of even one cycle therefore shows up as a wrong total, with no need to hit exact edges.

// File: rtl/cam_frame_timer.sv
module cam_frame_timer #(
  parameter int LW = 12,
  parameter int VW = 10,
  parameter int PW = 13,
  parameter int EW = 16,
  parameter int PAUSE_LINES = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] cfg_line_len,
  input  logic [LW-1:0] cfg_hblank,
  input  logic [VW-1:0] cfg_voff,
  input  logic [VW-1:0] cfg_lines,
  input  logic [PW-1:0] cfg_pixels,
  input  logic          cfg_hbin,
  input  logic [1:0]    cfg_geom,
  input  logic          cfg_px10,
  input  logic          cfg_ovl_readout,
  input  logic [EW-1:0] cfg_exp_min,
  input  logic [EW-1:0] cfg_exp_dly,
  input  logic          exp_start,
  input  logic          exp_stop,
  output logic          fval,
  output logic          lval,
  output logic          dval,
  output logic          exp_act,
  output logic [3:0]    tap_cnt,
  output logic          spare_dval,
  output logic          spare_exp
);
  localparam int PCW = LW + $clog2(PAUSE_LINES + 1);

  logic [LW-1:0]  line_len, hblank, hc;
  logic [VW-1:0]  voff, nlines;
  logic [VW:0]    lc;
  logic [PW-1:0]  pix_eff;
  logic [PW:0]    px;
  logic [3:0]     taps;
  logic           wide80;
  logic [PCW-1:0] pc;
  logic [EW-1:0]  ecnt, dcnt;
  logic           end_seen, dly_run, pend;

  function automatic logic [3:0] geom_taps(input logic [1:0] g);
    case (g)
      2'd0: geom_taps = 4'd2;
      2'd1: geom_taps = 4'd4;
      2'd2: geom_taps = 4'd8;
      default: geom_taps = 4'd10;
    endcase
  endfunction

  wire          exp_go    = exp_start && !exp_act;
  wire          exp_done  = exp_act && (exp_stop || end_seen) && (ecnt >= cfg_exp_min);
  wire          frm_go    = !fval && (pend || (dly_run && dcnt == '0));
  wire          paused    = pc != '0;
  wire          line_end  = hc == line_len - LW'(1);
  wire [VW:0]   tot_lines = {1'b0, voff} + {1'b0, nlines};
  wire          last_line = lc == tot_lines - (VW+1)'(1);
  wire          in_active = lc >= {1'b0, voff};
  wire [PW:0]   rem       = {1'b0, pix_eff} - px;
  wire          stall_trig = exp_go && cfg_ovl_readout && fval && !paused && !(line_end && last_line);

  assign lval       = fval && !paused && in_active && (hc < line_len - hblank);
  assign dval       = lval && (px < {1'b0, pix_eff});
  assign tap_cnt    = !dval ? 4'd0 : (rem < (PW+1)'(taps)) ? rem[3:0] : taps;
  assign spare_dval = dval && !wide80;
  assign spare_exp  = exp_act && !wide80;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_act <= 1'b0; ecnt <= '0; end_seen <= 1'b0;
      dly_run <= 1'b0; dcnt <= '0; pend <= 1'b0;
    end else begin
      if (dly_run && dcnt == '0) begin
        dly_run <= 1'b0;
        if (fval) pend <= 1'b1;
      end else if (dly_run) begin
        dcnt <= dcnt - EW'(1);
      end
      if (frm_go) pend <= 1'b0;
      if (exp_go) begin
        exp_act  <= 1'b1;
        ecnt     <= EW'(1);
        end_seen <= 1'b0;
      end else if (exp_done) begin
        exp_act <= 1'b0;
        dly_run <= 1'b1;
        dcnt    <= cfg_exp_dly;
      end else if (exp_act) begin
        if (ecnt != '1) ecnt <= ecnt + EW'(1);
        if (exp_stop) end_seen <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fval <= 1'b0; hc <= '0; lc <= '0; px <= '0; pc <= '0;
      line_len <= '0; hblank <= '0; voff <= '0; nlines <= '0;
      pix_eff <= '0; taps <= 4'd2; wide80 <= 1'b0;
    end else if (frm_go) begin
      fval     <= 1'b1;
      hc       <= '0;
      lc       <= '0;
      px       <= '0;
      pc       <= '0;
      line_len <= cfg_line_len;
      hblank   <= cfg_hblank;
      voff     <= cfg_voff;
      nlines   <= cfg_lines;
      pix_eff  <= cfg_hbin ? (cfg_pixels >> 1) : cfg_pixels;
      taps     <= geom_taps(cfg_geom);
      wide80   <= (cfg_geom == 2'd3 && !cfg_px10) || (cfg_geom == 2'd2 && cfg_px10);
    end else if (fval) begin
      if (paused) begin
        pc <= pc - PCW'(1);
      end else begin
        if (stall_trig) pc <= PCW'(PAUSE_LINES) * PCW'(line_len);
        if (line_end) begin
          hc <= '0;
          px <= '0;
          if (last_line) fval <= 1'b0;
          else lc <= lc + (VW+1)'(1);
        end else begin
          hc <= hc + LW'(1);
          if (dval) px <= px + (PW+1)'(taps);
        end
      end
    end else begin
      pc <= '0;
    end
  end

  AST_FRAME_OPENS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(fval) |-> (hc == '0 && lc == '0 && px == '0 && !paused)); // R3
  AST_PAUSE_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (fval && paused) |=> (fval && $stable(hc) && $stable(lc) && $stable(px))); // R7
  AST_EXP_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (exp_act && ecnt < cfg_exp_min && $stable(cfg_exp_min)) |=> exp_act); // R12
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    (fval && $past(fval)) |-> ($stable(line_len) && $stable(nlines) && $stable(taps))); // R13
endmodule

// File: tb/cam_frame_timer_test.sv
module cam_frame_timer_test;
  logic clk = 0, rst = 1;
  logic [11:0] cfg_line_len = 12'd40, cfg_hblank = 12'd8;
  logic [9:0]  cfg_voff = 10'd3, cfg_lines = 10'd5;
  logic [12:0] cfg_pixels = 13'd100;
  logic cfg_hbin = 0, cfg_px10 = 0, cfg_ovl_readout = 1;
  logic [1:0]  cfg_geom = 2'd1;
  logic [15:0] cfg_exp_min = 16'd5, cfg_exp_dly = 16'd7;
  logic exp_start = 0, exp_stop = 0;
  logic fval, lval, dval, exp_act, spare_dval, spare_exp;
  logic [3:0] tap_cnt;

  cam_frame_timer uut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int frames = 0;
  int f_cyc, l_cyc, d_cyc, pix, sp_mis, sp_hi, e_in_f, first_l;
  int r_f, r_l, r_d, r_pix, r_mis, r_hi, r_ein, r_first;
  int e_w, r_ew, gap, r_gap;
  bit armed, prev_f, prev_e, done;

  always @(negedge clk) begin
    if (rst) begin
      prev_f = 0; prev_e = 0; armed = 0;
    end else begin
      if (exp_act && !prev_e) e_w = 0;
      if (exp_act) e_w++;
      if (!exp_act && prev_e) begin r_ew = e_w; armed = 1; gap = 0; end
      else if (armed) gap++;
      if (fval && !prev_f) begin
        if (armed) begin r_gap = gap; armed = 0; end
        f_cyc = 0; l_cyc = 0; d_cyc = 0; pix = 0; sp_mis = 0; sp_hi = 0; e_in_f = 0; first_l = -1;
      end
      if (fval) begin
        if (lval && first_l < 0) first_l = f_cyc;
        f_cyc++;
        if (lval) l_cyc++;
        if (dval) d_cyc++;
        pix += tap_cnt;
        if (spare_dval != dval || spare_exp != exp_act) sp_mis++;
        if (spare_dval || spare_exp) sp_hi++;
        if (exp_act) e_in_f++;
      end
      if (!fval && prev_f) begin
        r_f = f_cyc; r_l = l_cyc; r_d = d_cyc; r_pix = pix; r_mis = sp_mis;
        r_hi = sp_hi; r_ein = e_in_f; r_first = first_l;
        frames++;
      end
      prev_f = fval; prev_e = exp_act;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expose();
    @(posedge clk); #1 exp_start = 1;
    @(posedge clk); #1 exp_start = 0; exp_stop = 1;
    @(posedge clk); #1 exp_stop = 0;
  endtask

  task automatic wait_frames(input int n);
    int target = frames + n;
    while (frames < target) @(posedge clk);
  endtask

  task automatic mid_frame_expose(input int n);
    while (!fval) @(posedge clk);
    repeat (n) @(posedge clk);
    expose();
  endtask

  task automatic set_fmt(input int px, input bit hb, input int g, input bit p10);
    cfg_pixels = 13'(px); cfg_hbin = hb; cfg_geom = 2'(g); cfg_px10 = p10;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!fval && !lval && !dval && !exp_act && !spare_dval && !spare_exp && tap_cnt == 0,
        "R1 outputs low in reset", int'(fval | lval | dval | exp_act), 0);
  endtask

  task automatic t_basic();
    set_fmt(100, 0, 1, 0); cfg_ovl_readout = 1;
    expose();
    wait_frames(1);
    chk(r_ew == 5, "R12 exposure min width", r_ew, 5);
    chk(r_gap == 8, "R2 exposure end to fval", r_gap, 8);
    chk(r_f == 320, "R3 R8 frame length", r_f, 320);
    chk(r_first == 120, "R3 offset lines before first lval", r_first, 120);
    chk(r_l == 160, "R4 lval cycles", r_l, 160);
    chk(r_d == 125, "R5 dval slots 4 taps", r_d, 125);
    chk(r_pix == 500, "R5 pixel total 4 taps", r_pix, 500);
    chk(r_mis == 0, "R10 spare bits mirror", r_mis, 0);
  endtask

  task automatic t_taps();
    set_fmt(95, 0, 3, 1);
    expose(); wait_frames(1);
    chk(r_d == 50, "R5 dval slots 10 taps", r_d, 50);
    chk(r_pix == 475, "R5 pixel total 10 taps short slot", r_pix, 475);
    set_fmt(60, 0, 0, 0);
    expose(); wait_frames(1);
    chk(r_d == 150, "R5 dval slots 2 taps", r_d, 150);
    chk(r_pix == 300, "R5 pixel total 2 taps", r_pix, 300);
  endtask

  task automatic t_hbin();
    set_fmt(100, 1, 1, 0);
    expose(); wait_frames(1);
    chk(r_pix == 250, "R6 binned pixel total", r_pix, 250);
    chk(r_d == 65, "R6 binned dval slots", r_d, 65);
    chk(r_f == 320, "R6 frame length kept", r_f, 320);
  endtask

  task automatic t_pause();
    set_fmt(100, 0, 1, 0); cfg_ovl_readout = 1;
    expose();
    mid_frame_expose(100);
    wait_frames(1);
    chk(r_f == 960, "R7 fval extended 16 lines", r_f, 960);
    chk(r_l == 160, "R7 lval cycles kept", r_l, 160);
    chk(r_pix == 500, "R7 pixels kept", r_pix, 500);
    wait_frames(1);
    chk(r_f == 320, "R8 next frame normal", r_f, 320);
  endtask

  task automatic t_nopause();
    set_fmt(100, 0, 1, 0); cfg_ovl_readout = 0;
    expose();
    mid_frame_expose(100);
    wait_frames(1);
    chk(r_f == 320, "R9 no extension without overlap mode", r_f, 320);
    chk(r_ein > 0 && r_mis == 0, "R10 spare_exp mirrors in frame", r_mis, 0);
    wait_frames(1);
    cfg_ovl_readout = 1;
  endtask

  task automatic t_wide80();
    cfg_ovl_readout = 0;
    set_fmt(100, 0, 3, 0);
    expose(); mid_frame_expose(60); wait_frames(1);
    chk(r_d == 50 && r_ein > 0, "R11 10x8 frame active", r_d, 50);
    chk(r_hi == 0, "R11 spare low 10 taps 8 bit", r_hi, 0);
    wait_frames(1);
    set_fmt(96, 0, 2, 1);
    expose(); mid_frame_expose(60); wait_frames(1);
    chk(r_d == 60 && r_ein > 0, "R11 8x10 frame active", r_d, 60);
    chk(r_hi == 0, "R11 spare low 8 taps 10 bit", r_hi, 0);
    wait_frames(1);
    cfg_ovl_readout = 1;
  endtask

  task automatic t_sample();
    set_fmt(100, 0, 1, 0);
    expose();
    while (!fval) @(posedge clk);
    repeat (20) @(posedge clk);
    #1 cfg_line_len = 12'd60; cfg_voff = 10'd0; cfg_geom = 2'd0;
    wait_frames(1);
    chk(r_f == 320, "R13 frame length uses captured config", r_f, 320);
    chk(r_pix == 500 && r_d == 125, "R13 pixel format captured", r_d, 125);
    cfg_line_len = 12'd40; cfg_voff = 10'd3; cfg_geom = 2'd1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", frames, -1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(posedge clk); #1 rst = 0;
    t_basic();
    t_taps();
    t_hbin();
    t_pause();
    t_nopause();
    t_wide80();
    t_sample();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule